// File: doc/BRIEF.md
# Fan PWM Generator with Edge-Point Compare

This block drives one fan control output from a pulse-width waveform whose edges are placed by two compare points instead of a single duty value. The input clock first passes through a two-stage prescaler: a power-of-two stage set by an exponent field, then a stage that divides by twice its field value, or by one when the field is zero. A period counter advances once per prescaler tick and runs from zero up to a programmed terminal value before returning to zero. The output rises when the counter reaches the rise point and drops when it reaches a nonzero fall point. A fall point of zero never pulls the output low, so rise 0 with fall 0 gives a constant high level.

Software or a sequencer loads the settings through a byte-wide write strobe. New timing values are copied into the working set only when the counter wraps, so a period in progress always finishes with the settings it started with. A port-enable bit holds the counter and prescaler in their cleared state and forces the output low. A clock-enable bit freezes the prescaler and counter where they stand.

Top module: `fan_pwm_gen`

## Requirements
- R1: Writes are decoded on `wr_addr` when `wr_en` is high: address 0 is control (bit 0 clock enable, bit 1 port enable), 1 is the high-stage exponent, 2 is the low-stage divisor, 3 is the period terminal count, 4 is the rise point, 5 is the fall point. Writes to addresses 6 and 7 change nothing.
- R2: Synchronous reset clears every field to zero and drives `pwm_out` low. If only the two enable bits are set afterwards, the output is constantly high.
- R3: The output repeats every 2^H × L' × (P+1) input clocks, where H is the exponent, P the period field, and L' is 1 for a low divisor of 0 and 2×L otherwise.
- R4: The counter never exceeds the period value while enabled. With rise R below a nonzero fall F, the output is high for (F−R) ticks per period. With R above F, it is high for (P+1−R+F) ticks.
- R5: With rise 0 and fall 0, the output is high on every cycle after the port starts.
- R6: While the port is disabled, the output is low one cycle after the disable and the counter stays at zero. After enabling with rise 0, the output is still low on the cycle the enable is written and high on the next cycle.
- R7: While the port is enabled and the clock enable is low, the counter and the output do not change.
- R8: Period, rise, fall and divisor writes made during a period take effect only from the next counter wrap. The period already running keeps its old high time.
- R9: When rise and fall are equal and nonzero, the output stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | 3 | Field select for the write |
| wr_data | input | 8 | Write data |
| pwm_out | output | 1 | Registered fan PWM output |

## Verification
The bound checker tests these properties on every cycle: the counter stays within the working period, the working settings change only at a wrap or while disabled, a disabled port gives a cleared counter and a low output, a gated clock gives a frozen counter, and rise 0 with fall 0 gives a high output. What the assertions cannot show, and only the bench scenarios can, is the end-to-end waveform: the edge-to-edge period across several prescaler settings, the high time for ordered and wrapped compare points, the exact latency from enable to the first high cycle, and the old fall point staying in force for the rest of a period after a new one is written.

// File: rtl/fanpwm_pkg.sv
package fanpwm_pkg;

  localparam int FP_ADDR_W = 3;

  typedef enum logic [FP_ADDR_W-1:0] {
    FP_A_CTRL   = 3'd0,
    FP_A_HIEXP  = 3'd1,
    FP_A_LODIV  = 3'd2,
    FP_A_PERIOD = 3'd3,
    FP_A_RISE   = 3'd4,
    FP_A_FALL   = 3'd5
  } fp_addr_e;

  localparam int FP_CTRL_CLKEN_BIT  = 0;
  localparam int FP_CTRL_PORTEN_BIT = 1;

endpackage

// File: rtl/fp_regs.sv
module fp_regs
  import fanpwm_pkg::*;
#(
  parameter int HI_EXP_W = 4,
  parameter int LO_DIV_W = 4,
  parameter int CNT_W    = 8,
  parameter int DATA_W   = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [FP_ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0]    wr_data,
  output logic                 clk_en,
  output logic                 port_en,
  output logic [HI_EXP_W-1:0]  sh_hi,
  output logic [LO_DIV_W-1:0]  sh_lo,
  output logic [CNT_W-1:0]     sh_per,
  output logic [CNT_W-1:0]     sh_rise,
  output logic [CNT_W-1:0]     sh_fall
);

  // R1 field decode; unknown addresses fall through with no update
  always_ff @(posedge clk) begin
    if (rst) begin
      clk_en  <= 1'b0;
      port_en <= 1'b0;
      sh_hi   <= '0;
      sh_lo   <= '0;
      sh_per  <= '0;
      sh_rise <= '0;
      sh_fall <= '0;
    end else if (wr_en) begin
      case (fp_addr_e'(wr_addr))
        FP_A_CTRL: begin
          clk_en  <= wr_data[FP_CTRL_CLKEN_BIT];
          port_en <= wr_data[FP_CTRL_PORTEN_BIT];
        end
        FP_A_HIEXP:  sh_hi   <= wr_data[HI_EXP_W-1:0];
        FP_A_LODIV:  sh_lo   <= wr_data[LO_DIV_W-1:0];
        FP_A_PERIOD: sh_per  <= wr_data[CNT_W-1:0];
        FP_A_RISE:   sh_rise <= wr_data[CNT_W-1:0];
        FP_A_FALL:   sh_fall <= wr_data[CNT_W-1:0];
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/fp_cfg_latch.sv
module fp_cfg_latch #(
  parameter int HI_EXP_W = 4,
  parameter int LO_DIV_W = 4,
  parameter int CNT_W    = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic [HI_EXP_W-1:0] sh_hi,
  input  logic [LO_DIV_W-1:0] sh_lo,
  input  logic [CNT_W-1:0]    sh_per,
  input  logic [CNT_W-1:0]    sh_rise,
  input  logic [CNT_W-1:0]    sh_fall,
  output logic [HI_EXP_W-1:0] act_hi,
  output logic [LO_DIV_W-1:0] act_lo,
  output logic [CNT_W-1:0]    act_per,
  output logic [CNT_W-1:0]    act_rise,
  output logic [CNT_W-1:0]    act_fall
);

  localparam int NCMP = 3;

  logic [CNT_W-1:0] sh_cmp  [NCMP];
  logic [CNT_W-1:0] act_cmp [NCMP];

  assign sh_cmp[0] = sh_per;
  assign sh_cmp[1] = sh_rise;
  assign sh_cmp[2] = sh_fall;

  // R8 working copy refreshed only at a wrap or while the port is idle
  for (genvar g = 0; g < NCMP; g++) begin : g_cmp
    always_ff @(posedge clk) begin
      if (rst)       act_cmp[g] <= '0;
      else if (load) act_cmp[g] <= sh_cmp[g];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_hi <= '0;
      act_lo <= '0;
    end else if (load) begin
      act_hi <= sh_hi;
      act_lo <= sh_lo;
    end
  end

  assign act_per  = act_cmp[0];
  assign act_rise = act_cmp[1];
  assign act_fall = act_cmp[2];

endmodule

// File: rtl/fp_prescaler.sv
module fp_prescaler #(
  parameter int HI_EXP_W = 4,
  parameter int LO_DIV_W = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clr,
  input  logic                run,
  input  logic [HI_EXP_W-1:0] hi_exp,
  input  logic [LO_DIV_W-1:0] lo_div,
  output logic                tick
);

  localparam int HI_CNT_W = (1 << HI_EXP_W) - 1;
  localparam int LO_CNT_W = LO_DIV_W + 1;

  logic [HI_CNT_W-1:0] hi_cnt, hi_max;
  logic [LO_CNT_W-1:0] lo_cnt, lo_max;
  logic                hi_last, lo_last;

  // power-of-two stage: terminal count is 2^exp - 1
  assign hi_max  = ~({HI_CNT_W{1'b1}} << hi_exp);
  // second stage: zero divides by one, N divides by 2N
  assign lo_max  = (lo_div == '0) ? '0 : ({lo_div, 1'b0} - 1'b1);
  assign hi_last = (hi_cnt >= hi_max);
  assign lo_last = (lo_cnt >= lo_max);
  assign tick    = run && hi_last && lo_last;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      hi_cnt <= '0;
    end else if (run) begin
      hi_cnt <= hi_last ? '0 : hi_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      lo_cnt <= '0;
    end else if (run && hi_last) begin
      lo_cnt <= lo_last ? '0 : lo_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/fp_period_cnt.sv
module fp_period_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             tick,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);

  assign wrap = tick && (cnt >= period);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (wrap) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/fp_edge_out.sv
module fp_edge_out #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] rise,
  input  logic [CNT_W-1:0] fall,
  output logic             pwm
);

  logic hit_rise, hit_fall;

  assign hit_rise = (cnt == rise);
  assign hit_fall = (fall != '0) && (cnt == fall);

  // fall has priority, so equal nonzero points give a low output (R9)
  always_ff @(posedge clk) begin
    if (rst || !en)    pwm <= 1'b0;
    else if (hit_fall) pwm <= 1'b0;
    else if (hit_rise) pwm <= 1'b1;
  end

endmodule

// File: rtl/fan_pwm_gen.sv
module fan_pwm_gen
  import fanpwm_pkg::*;
#(
  parameter int HI_EXP_W = 4,
  parameter int LO_DIV_W = 4,
  parameter int CNT_W    = 8,
  parameter int DATA_W   = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [FP_ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0]    wr_data,
  output logic                 pwm_out
);

  logic                clk_en_q, port_en_q;
  logic [HI_EXP_W-1:0] sh_hi, act_hi;
  logic [LO_DIV_W-1:0] sh_lo, act_lo;
  logic [CNT_W-1:0]    sh_per, sh_rise, sh_fall;
  logic [CNT_W-1:0]    act_per, act_rise, act_fall;
  logic [CNT_W-1:0]    cnt;
  logic                tick, wrap, cfg_load;

  assign cfg_load = !port_en_q || wrap;

  fp_regs #(
    .HI_EXP_W(HI_EXP_W), .LO_DIV_W(LO_DIV_W), .CNT_W(CNT_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .clk_en(clk_en_q), .port_en(port_en_q),
    .sh_hi(sh_hi), .sh_lo(sh_lo), .sh_per(sh_per),
    .sh_rise(sh_rise), .sh_fall(sh_fall)
  );

  fp_cfg_latch #(
    .HI_EXP_W(HI_EXP_W), .LO_DIV_W(LO_DIV_W), .CNT_W(CNT_W)
  ) u_cfg (
    .clk(clk), .rst(rst), .load(cfg_load),
    .sh_hi(sh_hi), .sh_lo(sh_lo), .sh_per(sh_per),
    .sh_rise(sh_rise), .sh_fall(sh_fall),
    .act_hi(act_hi), .act_lo(act_lo), .act_per(act_per),
    .act_rise(act_rise), .act_fall(act_fall)
  );

  fp_prescaler #(
    .HI_EXP_W(HI_EXP_W), .LO_DIV_W(LO_DIV_W)
  ) u_pre (
    .clk(clk), .rst(rst), .clr(!port_en_q), .run(clk_en_q),
    .hi_exp(act_hi), .lo_div(act_lo), .tick(tick)
  );

  fp_period_cnt #(
    .CNT_W(CNT_W)
  ) u_cnt (
    .clk(clk), .rst(rst), .clr(!port_en_q), .tick(tick),
    .period(act_per), .cnt(cnt), .wrap(wrap)
  );

  fp_edge_out #(
    .CNT_W(CNT_W)
  ) u_out (
    .clk(clk), .rst(rst), .en(port_en_q), .cnt(cnt),
    .rise(act_rise), .fall(act_fall), .pwm(pwm_out)
  );

endmodule

// File: rtl/fan_pwm_gen_chk.sv
module fan_pwm_gen_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             port_en,
  input logic             clk_en,
  input logic             wrap,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] act_per,
  input logic [CNT_W-1:0] act_rise,
  input logic [CNT_W-1:0] act_fall,
  input logic             pwm_out
);

  // R2: reset drives the output low
  a_r2_reset_low: assert property (@(posedge clk) rst |=> !pwm_out);

  // R4: counter stays inside the working period
  a_r4_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    port_en |-> (cnt <= act_period_w));

  // R5: rise 0 / fall 0 at count 0 gives a high output
  a_r5_full_high: assert property (@(posedge clk) disable iff (rst)
    (port_en && act_rise == '0 && act_fall == '0 && cnt == '0) |=> pwm_out);

  // R6: disabled port clears counter and output
  a_r6_disabled_low: assert property (@(posedge clk) disable iff (rst)
    !port_en |=> !pwm_out);
  a_r6_cnt_held: assert property (@(posedge clk) disable iff (rst)
    !port_en |=> (cnt == '0));

  // R7: gated clock freezes the counter
  a_r7_freeze: assert property (@(posedge clk) disable iff (rst)
    (port_en && !clk_en) |=> $stable(cnt));

  // R8: working settings move only at a wrap
  a_r8_wrap_only: assert property (@(posedge clk) disable iff (rst)
    (port_en && !wrap) |=> ($stable(act_per) && $stable(act_rise) && $stable(act_fall)));

  logic [CNT_W-1:0] act_period_w;
  assign act_period_w = act_per;

endmodule

bind fan_pwm_gen fan_pwm_gen_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .port_en(port_en_q), .clk_en(clk_en_q), .wrap(wrap),
  .cnt(cnt), .act_per(act_per), .act_rise(act_rise), .act_fall(act_fall),
  .pwm_out(pwm_out)
);

// File: tb/fan_pwm_gen_test.sv
module fan_pwm_gen_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       pwm_out;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  fan_pwm_gen uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pwm_out(pwm_out)
  );

  typedef struct packed {
    logic [7:0]  h, l, p, r, f;
    logic [15:0] per, hi;
  } vec_t;

  // R3 / R4 vectors: exponent, low divisor, period, rise, fall, cycles, high cycles
  localparam vec_t VECS [6] = '{
    vec_t'{8'd0, 8'd0, 8'd9,  8'd0, 8'd5,  16'd10,  16'd5},
    vec_t'{8'd1, 8'd0, 8'd9,  8'd2, 8'd7,  16'd20,  16'd10},
    vec_t'{8'd0, 8'd1, 8'd4,  8'd0, 8'd1,  16'd10,  16'd2},
    vec_t'{8'd2, 8'd3, 8'd3,  8'd1, 8'd3,  16'd96,  16'd48},
    vec_t'{8'd0, 8'd0, 8'd7,  8'd6, 8'd2,  16'd8,   16'd4},
    vec_t'{8'd1, 8'd2, 8'd15, 8'd0, 8'd12, 16'd128, 16'd96}
  };

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic find_rise(output bit ok);
    logic prev;
    prev = pwm_out;
    ok = 1'b0;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (pwm_out && !prev) begin
        ok = 1'b1;
        return;
      end
      prev = pwm_out;
    end
  endtask

  task automatic measure(output int per, output int hi);
    bit ok;
    logic prev;
    find_rise(ok);
    per = -1; hi = -1;
    if (!ok) return;
    per = 1; hi = 1; prev = 1'b1;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (pwm_out && !prev) return;
      per++;
      if (pwm_out) hi++;
      prev = pwm_out;
    end
  endtask

  task automatic count_high(input int n, output int hi);
    hi = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm_out) hi++;
    end
  endtask

  task automatic setup(input logic [7:0] h, l, p, r, f);
    wr(3'd0, 8'h00);
    wr(3'd1, h); wr(3'd2, l); wr(3'd3, p); wr(3'd4, r); wr(3'd5, f);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: got 0 expected 1 (run ended)");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : main
    int per, hi, h;
    bit ok;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R2: idle after reset
    count_high(50, hi);
    check("R2 low after reset", hi, 0);

    // R3/R4: table walk
    foreach (VECS[k]) begin
      setup(VECS[k].h, VECS[k].l, VECS[k].p, VECS[k].r, VECS[k].f);
      wr(3'd0, 8'h03);
      measure(per, hi);
      measure(per, hi);
      check($sformatf("R3 period vec%0d", k), per, VECS[k].per);
      check($sformatf("R4 high time vec%0d", k), hi, VECS[k].hi);
    end

    // R1: addresses 6 and 7 ignored
    wr(3'd6, 8'hFF);
    wr(3'd7, 8'h00);
    measure(per, hi);
    measure(per, hi);
    check("R1 ignored addr period", per, 128);
    check("R1 ignored addr high", hi, 96);

    // R6: enable latency with rise 0
    setup(8'd0, 8'd0, 8'd9, 8'd0, 8'd5);
    wr(3'd0, 8'h03);
    check("R6 low on enable cycle", int'(pwm_out), 0);
    @(negedge clk);
    check("R6 high next cycle", int'(pwm_out), 1);

    // R8: fall written mid-period applies from next wrap
    find_rise(ok);
    wr(3'd5, 8'd8);
    h = 2;
    while (pwm_out && h < 100) begin
      h++;
      @(negedge clk);
    end
    check("R8 old fall kept", h, 5);
    find_rise(ok);
    h = 1;
    @(negedge clk);
    while (pwm_out && h < 100) begin
      h++;
      @(negedge clk);
    end
    check("R8 new fall used", h, 8);

    // R7: clock gate freezes output, then resumes
    wr(3'd5, 8'd5);
    repeat (30) @(negedge clk);
    wr(3'd0, 8'h02);
    @(negedge clk);
    begin
      logic v;
      int diff;
      v = pwm_out; diff = 0;
      for (int i = 0; i < 200; i++) begin
        @(negedge clk);
        if (pwm_out !== v) diff++;
      end
      check("R7 frozen output", diff, 0);
    end
    wr(3'd0, 8'h03);
    measure(per, hi);
    measure(per, hi);
    check("R7 resumed period", per, 10);

    // R6: disable forces low
    wr(3'd0, 8'h01);
    @(negedge clk);
    count_high(100, hi);
    check("R6 disabled low", hi, 0);

    // R5: rise 0 fall 0 constant high
    setup(8'd0, 8'd0, 8'd9, 8'd0, 8'd0);
    wr(3'd0, 8'h03);
    repeat (3) @(negedge clk);
    count_high(60, hi);
    check("R5 always high", hi, 60);

    // R9: equal nonzero points stay low
    setup(8'd0, 8'd0, 8'd9, 8'd3, 8'd3);
    wr(3'd0, 8'h03);
    count_high(80, hi);
    check("R9 equal points low", hi, 0);

    // R2: reset mid-run clears fields
    setup(8'd0, 8'd0, 8'd9, 8'd2, 8'd6);
    wr(3'd0, 8'h03);
    repeat (20) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    count_high(30, hi);
    check("R2 low after mid-run reset", hi, 0);
    wr(3'd0, 8'h03);
    repeat (3) @(negedge clk);
    count_high(40, hi);
    check("R2 zeroed fields give high", hi, 40);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule